// File: doc/BRIEF.md
# Pixel hit arrival-time and duration digitizer

This block sits inside one readout pixel and turns a discriminated detector hit into three numbers. When the asynchronous hit level goes high, a 4-bit LFSR starts stepping on the fast clock (nominally 16 fast periods per system period). It keeps stepping until the next rising edge of the system clock, which gives the fine part of the arrival time. That system edge is the start edge. From the start edge on, a coarse counter counts system periods until a trigger that is synchronous to the system clock stops it. The trigger acts as a common stop, so the arrival time is counted backward from it. A second counter, started on the same edge, measures how long the hit stays above threshold.

The pixel takes one hit per cycle of operation. When the trigger is seen, the results are frozen and flagged valid. A clear input then rearms the pixel. Results are presented in parallel: the raw fine LFSR state, its decoded binary value, the coarse count, the time-over-threshold count and the valid flag.

Top module: `hit_tdc`

## Requirements
- R1: While rst_ni is low, fine_raw_o is 4'b0001, and fine_o, coarse_o, tot_o and valid_o are all zero.
- R2: The fine counter is the LFSR x^4+x^3+1, with next state {s[2:0], s[3]^s[2]} and seed 4'b0001. It is armed on the fast edge that first sees hit_i high after seeing it low. From the following fast edge on, it steps on every fast edge until the first fast edge that sees clk_sys_i high after having seen it low. That edge ends the count and does not step. fine_o is the number of steps, decoded from the LFSR state. A hit that lands j fast periods after a system edge (j = 1..15) gives 15-j.
- R3: The fine counter saturates at 14 (state 4'b1000) and never wraps back to the seed.
- R4: The start edge is the first system edge that sees the fine counter running. coarse_o counts the system edges after the start edge that sample trig_i low, up to the first edge after it that samples trig_i high. It then holds.
- R5: coarse_o saturates at all ones.
- R6: tot_o starts at zero on the start edge. It increments on each later system edge while running. hit_i passes through a two-stage synchronizer on the system clock. From the second edge after the start edge on, the first edge whose synchronized hit is low stops tot_o without incrementing. A hit last sampled high on system edge S+L-1 (L >= 1) and low on edge S+L gives L+1. A hit that falls before the start edge gives 1.
- R7: tot_o saturates at all ones and never decreases until clear.
- R8: valid_o rises on the system edge that samples the trigger. It stays high, with coarse_o and the fine result frozen, until a clear.
- R9: A trigger with no hit in progress has no effect. A clear while valid_o is low has no effect.
- R10: A hit rising while a measurement is running or waiting for clear is ignored. A hit level still high across a clear does not start a new measurement.
- R11: A system edge that samples clear_i high while valid_o is high returns coarse_o, tot_o and valid_o to zero. The fine counter returns to its seed before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fast_i | input | 1 | Fast clock for the fine counter |
| clk_sys_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| hit_i | input | 1 | Discriminated hit level, asynchronous |
| trig_i | input | 1 | Common-stop trigger, synchronous to clk_sys_i |
| clear_i | input | 1 | Rearm request, synchronous to clk_sys_i |
| fine_raw_o | output | 4 | Raw fine LFSR state |
| fine_o | output | 4 | Decoded fine count, 0 to 14 |
| coarse_o | output | COARSE_W | Start-to-trigger system period count |
| tot_o | output | TOT_W | Time-over-threshold count |
| valid_o | output | 1 | Result frozen and ready |

## Verification
Hits are placed at every fast-clock phase within a system period. Phase zero drives the fine counter into saturation and the last phase leaves it at zero, which separates off-by-one stop handling from a missing saturation. Hit lengths run from sub-period pulses to runs longer than the counter range, which separates the synchronizer warm-up window from plain level counting and from wrap-around. Trigger-only, clear-while-busy, second-hit and held-hit patterns show whether stray inputs leak into a frozen result or restart the pixel.

// File: rtl/hit_tdc_pkg.sv
package hit_tdc_pkg;
  localparam int unsigned FINE_W   = 4;
  localparam int unsigned FINE_MAX = 14;
  localparam logic [FINE_W-1:0] FINE_SEED = 4'b0001;

  // x^4 + x^3 + 1, shift left, feedback into bit 0
  function automatic logic [FINE_W-1:0] fine_step(input logic [FINE_W-1:0] s);
    return {s[2:0], s[3] ^ s[2]};
  endfunction

  function automatic logic [FINE_W-1:0] fine_state(input int unsigned n);
    logic [FINE_W-1:0] s;
    s = FINE_SEED;
    for (int unsigned i = 0; i < n; i++) s = fine_step(s);
    return s;
  endfunction

  function automatic logic [FINE_W-1:0] fine_decode(input logic [FINE_W-1:0] s);
    logic [FINE_W-1:0] r;
    logic [FINE_W-1:0] idx;
    r   = FINE_SEED;
    idx = '0;
    for (int i = 0; i <= int'(FINE_MAX); i++) begin
      if (r == s) idx = FINE_W'(i);
      r = fine_step(r);
    end
    return idx;
  endfunction
endpackage

// File: rtl/hit_tdc_fine.sv
module hit_tdc_fine
  import hit_tdc_pkg::*;
(
  input  logic              clk_fast_i,
  input  logic              rst_ni,
  input  logic              clk_sys_i,
  input  logic              hit_i,
  input  logic              valid_i,
  input  logic              clear_i,
  output logic              run_o,
  output logic [FINE_W-1:0] lfsr_o
);
  localparam logic [FINE_W-1:0] FINE_LAST = fine_state(FINE_MAX);

  logic              hit_q, sys_q, run_q, done_q;
  logic [FINE_W-1:0] lfsr_q;
  logic              sys_rise, hit_rise, rearm;

  assign sys_rise = clk_sys_i & ~sys_q;
  assign hit_rise = hit_i & ~hit_q;
  assign rearm    = done_q & valid_i & clear_i;

  always_ff @(posedge clk_fast_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hit_q  <= 1'b0;
      sys_q  <= 1'b0;
      run_q  <= 1'b0;
      done_q <= 1'b0;
      lfsr_q <= FINE_SEED;
    end else begin
      hit_q <= hit_i;
      sys_q <= clk_sys_i;
      if (rearm) begin
        done_q <= 1'b0;
        run_q  <= 1'b0;
        lfsr_q <= FINE_SEED;
      end else if (!run_q && !done_q && hit_rise) begin
        run_q <= 1'b1;
      end else if (run_q) begin
        if (sys_rise) begin
          run_q  <= 1'b0;
          done_q <= 1'b1;
        end else if (lfsr_q != FINE_LAST) begin
          lfsr_q <= fine_step(lfsr_q);
        end
      end
    end
  end

  assign run_o  = run_q;
  assign lfsr_o = lfsr_q;
endmodule

// File: rtl/hit_tdc_coarse.sv
module hit_tdc_coarse #(
  parameter int unsigned COARSE_W = 12
) (
  input  logic                clk_sys_i,
  input  logic                rst_ni,
  input  logic                run_fine_i,
  input  logic                trig_i,
  input  logic                clear_i,
  output logic                start_o,
  output logic                clr_o,
  output logic                valid_o,
  output logic [COARSE_W-1:0] coarse_o
);
  logic                busy_q, valid_q;
  logic [COARSE_W-1:0] coarse_q;

  assign clr_o   = clear_i & valid_q;
  assign start_o = run_fine_i & ~busy_q & ~valid_q;

  always_ff @(posedge clk_sys_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q   <= 1'b0;
      valid_q  <= 1'b0;
      coarse_q <= '0;
    end else if (clr_o) begin
      busy_q   <= 1'b0;
      valid_q  <= 1'b0;
      coarse_q <= '0;
    end else if (start_o) begin
      busy_q   <= 1'b1;
      coarse_q <= '0;
    end else if (busy_q) begin
      if (trig_i) begin
        busy_q  <= 1'b0;
        valid_q <= 1'b1;
      end else if (!(&coarse_q)) begin
        coarse_q <= coarse_q + COARSE_W'(1);
      end
    end
  end

  assign valid_o  = valid_q;
  assign coarse_o = coarse_q;
endmodule

// File: rtl/hit_tdc_tot.sv
module hit_tdc_tot #(
  parameter int unsigned TOT_W  = 12,
  parameter int unsigned SYNC_N = 2
) (
  input  logic             clk_sys_i,
  input  logic             rst_ni,
  input  logic             hit_i,
  input  logic             start_i,
  input  logic             clr_i,
  output logic [TOT_W-1:0] tot_o
);
  localparam int unsigned WARM_W = $clog2(SYNC_N + 1);
  localparam logic [WARM_W-1:0] WARM_LAST = WARM_W'(SYNC_N - 1);

  logic [SYNC_N-1:0] sync_q;
  logic              hit_s;

  if (SYNC_N == 1) begin : g_sync_one
    always_ff @(posedge clk_sys_i or negedge rst_ni) begin
      if (!rst_ni) sync_q <= '0;
      else         sync_q <= hit_i;
    end
  end else begin : g_sync_chain
    always_ff @(posedge clk_sys_i or negedge rst_ni) begin
      if (!rst_ni) sync_q <= '0;
      else         sync_q <= {sync_q[SYNC_N-2:0], hit_i};
    end
  end

  assign hit_s = sync_q[SYNC_N-1];

  logic              run_q;
  logic [WARM_W-1:0] warm_q;
  logic [TOT_W-1:0]  tot_q;
  logic              ready;

  // synchronizer output only trusted once it reflects post-start samples
  assign ready = (warm_q == WARM_LAST);

  always_ff @(posedge clk_sys_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      warm_q <= '0;
      tot_q  <= '0;
    end else if (clr_i) begin
      run_q  <= 1'b0;
      warm_q <= '0;
      tot_q  <= '0;
    end else if (start_i) begin
      run_q  <= 1'b1;
      warm_q <= '0;
      tot_q  <= '0;
    end else if (run_q) begin
      if (!ready) warm_q <= warm_q + WARM_W'(1);
      if (ready && !hit_s)  run_q <= 1'b0;
      else if (!(&tot_q))   tot_q <= tot_q + TOT_W'(1);
    end
  end

  assign tot_o = tot_q;
endmodule

// File: rtl/hit_tdc.sv
module hit_tdc
  import hit_tdc_pkg::*;
#(
  parameter int unsigned COARSE_W = 12,
  parameter int unsigned TOT_W    = 12,
  parameter int unsigned SYNC_N   = 2
) (
  input  logic                clk_fast_i,
  input  logic                clk_sys_i,
  input  logic                rst_ni,
  input  logic                hit_i,
  input  logic                trig_i,
  input  logic                clear_i,
  output logic [FINE_W-1:0]   fine_raw_o,
  output logic [FINE_W-1:0]   fine_o,
  output logic [COARSE_W-1:0] coarse_o,
  output logic [TOT_W-1:0]    tot_o,
  output logic                valid_o
);
  logic run_fine, start, clr;
  logic [FINE_W-1:0] lfsr;

  hit_tdc_fine u_fine (
    .clk_fast_i (clk_fast_i),
    .rst_ni     (rst_ni),
    .clk_sys_i  (clk_sys_i),
    .hit_i      (hit_i),
    .valid_i    (valid_o),
    .clear_i    (clear_i),
    .run_o      (run_fine),
    .lfsr_o     (lfsr)
  );

  hit_tdc_coarse #(.COARSE_W(COARSE_W)) u_coarse (
    .clk_sys_i  (clk_sys_i),
    .rst_ni     (rst_ni),
    .run_fine_i (run_fine),
    .trig_i     (trig_i),
    .clear_i    (clear_i),
    .start_o    (start),
    .clr_o      (clr),
    .valid_o    (valid_o),
    .coarse_o   (coarse_o)
  );

  hit_tdc_tot #(.TOT_W(TOT_W), .SYNC_N(SYNC_N)) u_tot (
    .clk_sys_i (clk_sys_i),
    .rst_ni    (rst_ni),
    .hit_i     (hit_i),
    .start_i   (start),
    .clr_i     (clr),
    .tot_o     (tot_o)
  );

  assign fine_raw_o = lfsr;
  assign fine_o     = fine_decode(lfsr);
endmodule

// File: rtl/hit_tdc_chk.sv
module hit_tdc_chk #(
  parameter int unsigned COARSE_W = 12,
  parameter int unsigned TOT_W    = 12
) (
  input logic                clk_fast_i,
  input logic                clk_sys_i,
  input logic                rst_ni,
  input logic                trig_i,
  input logic                clear_i,
  input logic [3:0]          fine_raw_o,
  input logic [COARSE_W-1:0] coarse_o,
  input logic [TOT_W-1:0]    tot_o,
  input logic                valid_o
);
  // R8
  valid_hold_chk: assert property (@(posedge clk_sys_i) disable iff (!rst_ni)
    valid_o && !clear_i |=> valid_o);
  // R8
  valid_rise_chk: assert property (@(posedge clk_sys_i) disable iff (!rst_ni)
    $rose(valid_o) |-> $past(trig_i));
  // R11
  clear_zero_chk: assert property (@(posedge clk_sys_i) disable iff (!rst_ni)
    clear_i && valid_o |=> !valid_o && coarse_o == '0 && tot_o == '0);
  // R4
  coarse_hold_chk: assert property (@(posedge clk_sys_i) disable iff (!rst_ni)
    valid_o && !clear_i |=> $stable(coarse_o));
  // R5
  coarse_sat_chk: assert property (@(posedge clk_sys_i) disable iff (!rst_ni)
    (&coarse_o) && !(clear_i && valid_o) |=> &coarse_o);
  // R7
  tot_mono_chk: assert property (@(posedge clk_sys_i) disable iff (!rst_ni)
    !(clear_i && valid_o) |=> tot_o >= $past(tot_o));
  // R2
  fine_nonzero_chk: assert property (@(posedge clk_fast_i) disable iff (!rst_ni)
    fine_raw_o != 4'b0000);
  // R10
  fine_frozen_chk: assert property (@(posedge clk_fast_i) disable iff (!rst_ni)
    valid_o && !clear_i |=> $stable(fine_raw_o));
endmodule

bind hit_tdc hit_tdc_chk #(.COARSE_W(COARSE_W), .TOT_W(TOT_W)) u_chk (
  .clk_fast_i (clk_fast_i),
  .clk_sys_i  (clk_sys_i),
  .rst_ni     (rst_ni),
  .trig_i     (trig_i),
  .clear_i    (clear_i),
  .fine_raw_o (fine_raw_o),
  .coarse_o   (coarse_o),
  .tot_o      (tot_o),
  .valid_o    (valid_o)
);

// File: tb/hit_tdc_tb_top.sv
`timescale 1ns/1ps
module hit_tdc_tb_top;
  localparam int FAST_PERIOD = 2;
  localparam int SYS_PERIOD  = 16 * FAST_PERIOD;
  localparam int CNT_W       = 6;
  localparam int CNT_MAX     = (1 << CNT_W) - 1;

  logic clk_fast = 1'b0, clk_sys = 1'b0, rst_n = 1'b0;
  logic hit = 1'b0, trig = 1'b0, clear = 1'b0;
  logic [3:0]       fine_raw, fine;
  logic [CNT_W-1:0] coarse, tot;
  logic             valid;
  int total = 0, bad = 0;

  always #(FAST_PERIOD/2) clk_fast = ~clk_fast;
  always #(SYS_PERIOD/2)  clk_sys  = ~clk_sys;

  hit_tdc #(.COARSE_W(CNT_W), .TOT_W(CNT_W), .SYNC_N(2)) dut_i (
    .clk_fast_i (clk_fast), .clk_sys_i (clk_sys), .rst_ni (rst_n),
    .hit_i (hit), .trig_i (trig), .clear_i (clear),
    .fine_raw_o (fine_raw), .fine_o (fine), .coarse_o (coarse),
    .tot_o (tot), .valid_o (valid)
  );

  function automatic int sat(input int v);
    return (v > CNT_MAX) ? CNT_MAX : v;
  endfunction

  function automatic int lfsr_after(input int n);
    logic [3:0] s = 4'b0001;
    for (int i = 0; i < n; i++) s = {s[2:0], s[3] ^ s[2]};
    return int'(s);
  endfunction

  function automatic int exp_fine(input int j);
    return (15 - j > 14) ? 14 : 15 - j;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_idle(input string tag);
    chk({tag, " R11 valid"}, int'(valid), 0);
    chk({tag, " R11 coarse"}, int'(coarse), 0);
    chk({tag, " R11 tot"}, int'(tot), 0);
    chk({tag, " R11 fine_raw"}, int'(fine_raw), 1);
  endtask

  task automatic do_clear();
    @(posedge clk_sys); #8 clear = 1'b1;
    @(posedge clk_sys); #8 clear = 1'b0;
    chk_idle("clear");
  endtask

  // hit j fast periods after a system edge; last high sample L edges after rise; trigger M edges after start
  task automatic run_case(input int j, input int l, input int m, input string tag);
    @(posedge clk_sys);
    #(FAST_PERIOD * j) hit = 1'b1;
    fork
      begin
        if (l == 0) begin
          #(FAST_PERIOD) hit = 1'b0;
        end else begin
          repeat (l) @(posedge clk_sys);
          #4 hit = 1'b0;
        end
      end
      begin
        repeat (m) @(posedge clk_sys);
        #8 trig = 1'b1;
        @(posedge clk_sys);
        #8 trig = 1'b0;
      end
    join
    repeat (3) @(posedge clk_sys);
    #8;
    chk({tag, " R2 fine"}, int'(fine), exp_fine(j));
    chk({tag, " R3 fine_raw"}, int'(fine_raw), lfsr_after(exp_fine(j)));
    chk({tag, " R4 R5 coarse"}, int'(coarse), sat(m - 1));
    chk({tag, " R6 R7 tot"}, int'(tot), sat((l == 0) ? 1 : l + 1));
    chk({tag, " R8 valid"}, int'(valid), 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk_fast);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int j, l, m;
    void'($urandom(32'd4711));
    #20;
    chk("R1 fine_raw", int'(fine_raw), 1);
    chk("R1 fine", int'(fine), 0);
    chk("R1 coarse", int'(coarse), 0);
    chk("R1 tot", int'(tot), 0);
    chk("R1 valid", int'(valid), 0);
    #20 rst_n = 1'b1;

    // R9 trigger alone
    @(posedge clk_sys); #8 trig = 1'b1;
    @(posedge clk_sys); #8 trig = 1'b0;
    repeat (2) @(posedge clk_sys); #8;
    chk("R9 trig-only valid", int'(valid), 0);
    chk("R9 trig-only coarse", int'(coarse), 0);

    run_case(0, 2, 3, "phase0 sat");      // R3
    do_clear();
    run_case(15, 1, 1, "phase15");
    do_clear();
    run_case(1, 3, 2, "phase1");
    do_clear();
    run_case(5, 0, 4, "short pulse");     // R6
    do_clear();
    run_case(7, 70, 70, "long sat");      // R5 R7
    do_clear();

    // R9 clear while busy, R10 second hit while busy
    @(posedge clk_sys); #6 hit = 1'b1;                  // j=3
    @(posedge clk_sys); #4 hit = 1'b0;                  // start edge S
    @(posedge clk_sys); #4 clear = 1'b1; hit = 1'b1;    // S+1
    @(posedge clk_sys); #4 clear = 1'b0; hit = 1'b0;    // S+2
    #4 trig = 1'b1;
    @(posedge clk_sys); #8 trig = 1'b0;                 // T=S+3
    repeat (2) @(posedge clk_sys); #8;
    chk("R9 clear-busy valid", int'(valid), 1);
    chk("R9 clear-busy coarse", int'(coarse), 2);
    chk("R10 second hit fine", int'(fine), 12);
    chk("R10 second hit tot", int'(tot), 2);
    do_clear();

    // R10 hit held across clear
    @(posedge clk_sys); #6 hit = 1'b1;
    repeat (2) @(posedge clk_sys); #8 trig = 1'b1;
    @(posedge clk_sys); #8 trig = 1'b0;
    do_clear();
    repeat (2) @(posedge clk_sys); #8 trig = 1'b1;
    @(posedge clk_sys); #8 trig = 1'b0;
    repeat (2) @(posedge clk_sys); #8;
    chk("R10 held hit valid", int'(valid), 0);
    chk("R10 held hit fine_raw", int'(fine_raw), 1);
    chk("R10 held hit coarse", int'(coarse), 0);
    hit = 1'b0;
    repeat (3) @(posedge clk_sys);

    for (int k = 0; k < 20; k++) begin
      j = int'($urandom_range(15, 0));
      l = int'($urandom_range(8, 0));
      m = int'($urandom_range(10, 1));
      if (j == 15 && l == 0) l = 1;
      run_case(j, l, m, "random");
      do_clear();
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule